// File: doc/BRIEF.md
# Edge-Select Event Counter and Pulse Measurement Timer

This block is one timer channel with a single external input pin. In event counting it treats the pin as its clock: every edge of the chosen polarity takes one off a down-counter. When the counter has reached zero, the next such edge restores it from a reload register and raises an interrupt. In measurement it counts a divided system clock between chosen pin edges. At each edge that ends an interval, the count moves into the reload register, where the processor can read it, and the counter starts again from zero.

The processor reaches the channel through a flat port with three word addresses: a mode byte, a run flag and a counter word. The pin passes through a two-stage synchronizer before its edges are used. A flag in the mode byte reports when a measurement ran past the counter's range, and a write to the mode byte clears it. The counter width is a parameter and is 16 bits by default.

Top module: `edge_meas_timer`

## Requirements
- R1: After reset the mode byte (address 0) reads 0, the run flag (address 1) reads 0, the counter word (address 2) reads 0 and the interrupt output is low.
- R2: Mode byte bits 1:0 select the function. Code 01 is event counting and code 10 is measurement. With code 00 or 11, nothing counts and nothing is captured, even while running.
- R3: In event counting, mode bits 3:2 pick the counted pin edge: 00 falling, 01 rising, 10 both, 11 none. Each counted edge decrements the counter by one. Address 2 reads the counter.
- R4: Bit 0 of address 1 is the run flag. While it is 0, pin edges and divided clocks leave the counter and the reload register unchanged.
- R5: In event counting, a counted edge that finds the counter at zero loads it from the reload register and drives the interrupt high for exactly one clock.
- R6: A write to address 2 while stopped loads both the counter and the reload register. While running, the same write loads only the reload register.
- R7: In measurement, mode bits 7:6 set the counted clock to the system clock divided by 2, 16, 64 or 512 (codes 00, 01, 10, 11). Bit 3 = 0 measures a period: bit 2 = 0 measures from falling edge to falling edge, and bit 2 = 1 from rising edge to rising edge.
- R8: In measurement with mode bit 3 = 1, every pin edge ends an interval, so the low and high phases are measured in turn.
- R9: At each interval-ending edge the counter is copied into the reload register and then cleared. Address 2 reads the reload register in measurement. If two edges are N = m*div + 1 system clocks apart, the captured value is m.
- R10: Every capture raises the interrupt for one clock, except the first capture after the run flag goes from 0 to 1.
- R11: Bit 5 of the mode byte reads 1 once the counter has wrapped past its all-ones value in measurement. It is read-only, and any write to address 0 clears it.
- R12: A pin change that meets the setup time of one clock edge takes effect on the counter at the third clock edge from that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the register port |
| busAddr | input | 2 | Word address: 0 mode, 1 run flag, 2 counter |
| busWData | input | CNT_W | Write data |
| busRData | output | CNT_W | Read data for busAddr, combinational |
| pinIn | input | 1 | Asynchronous external input pin |
| irq | output | 1 | One-clock interrupt request pulse |

## Verification
A pin change takes effect three clock edges later: two synchronizer stages, then the edge register. The bench therefore waits at least four clocks after each pin change before it reads the counter word. The interrupt and the capture come from the same edge, and a monitor counts the interrupt pulses at every falling clock edge. The checks compare changes in that count, not a single sampled cycle. Measurement intervals are always m*div + 1 clocks long, so exactly m divided clocks fall inside, whatever the prescaler phase. The overflow flag is read only after more than 2^CNT_W divided clocks have passed.

// File: rtl/emt_pkg.sv
package emt_pkg;

  typedef enum logic [1:0] {
    FN_OFF0  = 2'b00,
    FN_EVENT = 2'b01,
    FN_MEAS  = 2'b10,
    FN_OFF3  = 2'b11
  } fnSel_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_RUN   = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;

  // strobes from control to datapath, at most one counter action per cycle
  typedef struct packed {
    logic wrBoth;   // load counter and reload register
    logic wrBuf;    // load reload register only
    logic dec;      // event: count down
    logic reload;   // event: underflow, restore from reload register
    logic inc;      // measurement: one divided clock
    logic capture;  // measurement: copy to reload register, clear counter
    logic setOvf;
    logic clrOvf;
  } dpStrobe_t;

endpackage

// File: rtl/emt_edge_sync.sv
module emt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] syncQ;
  logic lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= pinAsync;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[STAGES-1];
  end

  assign rise = syncQ[STAGES-1] & ~lastQ;
  assign fall = ~syncQ[STAGES-1] & lastQ;
endmodule

// File: rtl/emt_ctrl.sv
module emt_ctrl
  import emt_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64,
  parameter int DIV3 = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] wrByte,
  input  logic       rise,
  input  logic       fall,
  input  logic       cntZero,
  input  logic       cntMax,
  output logic [7:0] modeReg,
  output logic       runQ,
  output dpStrobe_t  strobe,
  output logic       irq
);
  localparam int PRE_W = $clog2(DIV3);

  logic [PRE_W-1:0] preCnt, divLimit;
  logic firstPending;
  logic isEvent, isMeas, tick, evEdge, measEdge, capture;
  logic wrMode, wrRun, wrCount;
  fnSel_e fn;

  assign fn      = fnSel_e'(modeReg[1:0]);
  assign isEvent = (fn == FN_EVENT);
  assign isMeas  = (fn == FN_MEAS);
  assign wrMode  = busWr && (busAddr == ADDR_MODE);
  assign wrRun   = busWr && (busAddr == ADDR_RUN);
  assign wrCount = busWr && (busAddr == ADDR_COUNT);

  always_comb begin
    unique case (modeReg[7:6])
      2'b00:   divLimit = PRE_W'(DIV0 - 1);
      2'b01:   divLimit = PRE_W'(DIV1 - 1);
      2'b10:   divLimit = PRE_W'(DIV2 - 1);
      default: divLimit = PRE_W'(DIV3 - 1);
    endcase
  end

  // event edge choice by bits 3:2
  always_comb begin
    unique case (modeReg[3:2])
      2'b00:   evEdge = fall;
      2'b01:   evEdge = rise;
      2'b10:   evEdge = rise | fall;
      default: evEdge = 1'b0;
    endcase
  end

  // measurement: bit 3 width (every edge), else bit 2 polarity
  assign measEdge = modeReg[3] ? (rise | fall) : (modeReg[2] ? rise : fall);

  assign tick    = runQ && isMeas && (preCnt == divLimit);
  assign capture = runQ && isMeas && measEdge;

  always_ff @(posedge clk) begin
    if (!rstN || !runQ || !isMeas || tick) preCnt <= '0;
    else                                   preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe         = '0;
    strobe.wrBoth  = wrCount && !runQ;
    strobe.wrBuf   = wrCount && runQ;
    strobe.dec     = runQ && isEvent && evEdge && !cntZero;
    strobe.reload  = runQ && isEvent && evEdge && cntZero;
    strobe.capture = capture;
    strobe.inc     = tick && !capture;
    strobe.setOvf  = tick && !capture && cntMax;
    strobe.clrOvf  = wrMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg      <= '0;
      runQ         <= 1'b0;
      firstPending <= 1'b0;
      irq          <= 1'b0;
    end else begin
      if (wrMode) modeReg <= wrByte & 8'hDF;
      if (wrRun) runQ <= wrByte[0];
      if (wrRun && wrByte[0] && !runQ) firstPending <= 1'b1;
      else if (capture)                firstPending <= 1'b0;
      irq <= strobe.reload || (capture && !firstPending);
    end
  end
endmodule

// File: rtl/emt_datapath.sv
module emt_datapath
  import emt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] bufVal,
  output logic             ovfFlag,
  output logic             cntZero,
  output logic             cntMax
);
  assign cntZero = (cntVal == '0);
  assign cntMax  = &cntVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
      bufVal <= '0;
    end else if (strobe.wrBoth) begin
      cntVal <= wrData;
      bufVal <= wrData;
    end else begin
      if (strobe.capture)    bufVal <= cntVal;
      else if (strobe.wrBuf) bufVal <= wrData;

      if (strobe.capture)     cntVal <= '0;
      else if (strobe.reload) cntVal <= bufVal;
      else if (strobe.dec)    cntVal <= cntVal - 1'b1;
      else if (strobe.inc)    cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              ovfFlag <= 1'b0;
    else if (strobe.setOvf) ovfFlag <= 1'b1;
    else if (strobe.clrOvf) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/edge_meas_timer.sv
module edge_meas_timer
  import emt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWData,
  output logic [CNT_W-1:0] busRData,
  input  logic             pinIn,
  output logic             irq
);
  logic rise, fall, runQ, ovfFlag, cntZero, cntMax, irqQ;
  logic [7:0] modeReg;
  logic [CNT_W-1:0] cntVal, bufVal;
  dpStrobe_t strobe;

  emt_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .pinAsync(pinIn), .rise(rise), .fall(fall)
  );

  emt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .wrByte(busWData[7:0]), .rise(rise), .fall(fall),
    .cntZero(cntZero), .cntMax(cntMax), .modeReg(modeReg),
    .runQ(runQ), .strobe(strobe), .irq(irqQ)
  );

  emt_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWData),
    .cntVal(cntVal), .bufVal(bufVal), .ovfFlag(ovfFlag),
    .cntZero(cntZero), .cntMax(cntMax)
  );

  assign irq = irqQ;

  always_comb begin
    unique case (busAddr)
      ADDR_MODE:  busRData = CNT_W'(modeReg | {2'b00, ovfFlag, 5'b00000});
      ADDR_RUN:   busRData = CNT_W'(runQ);
      ADDR_COUNT: busRData = (modeReg[1:0] == FN_MEAS) ? bufVal : cntVal;
      default:    busRData = '0;
    endcase
  end
endmodule

// File: rtl/emt_checker.sv
module emt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic [7:0]       modeReg,
  input logic             runQ,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] bufVal,
  input logic             ovfFlag
);
  logic isMeas, isEvent;
  assign isMeas  = (modeReg[1:0] == 2'b10);
  assign isEvent = (modeReg[1:0] == 2'b01);

  assert_stopped_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !(busWr && busAddr == 2'd2)) |=> $stable(cntVal));

  assert_capture_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && isMeas && $past(isMeas)) |-> (cntVal == '0));

  assert_underflow_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irq && isEvent && $past(isEvent) && !$past(busWr)) |-> (cntVal == bufVal));

  assert_ovf_clear_by_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(busWr && busAddr == 2'd0));

  assert_irq_needs_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(runQ));
endmodule

bind edge_meas_timer emt_checker #(.CNT_W(CNT_W)) i_emt_checker (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .modeReg(modeReg), .runQ(runQ), .irq(irq), .cntVal(cntVal),
  .bufVal(bufVal), .ovfFlag(ovfFlag)
);

// File: tb/test_edge_meas_timer.sv
module test_edge_meas_timer;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [W-1:0] busWData = '0;
  logic [W-1:0] busRData;
  logic pinIn = 1'b0;
  logic irq;

  int checks = 0;
  int failures = 0;
  int irqCount = 0;
  bit summaryDone = 0;

  edge_meas_timer #(.CNT_W(W)) i_edge_meas_timer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .pinIn(pinIn), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (irq) irqCount++;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input int d);
    busWr = 1'b1; busAddr = a; busWData = W'(d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string req);
    busAddr = a;
    #1;
    check(req, int'(busRData), exp);
  endtask

  task automatic pulse();
    pinIn = 1'b1; wait_cyc(4);
    pinIn = 1'b0; wait_cyc(4);
  endtask

  function automatic int div_of(input int code);
    case (code)
      0: return 2;
      1: return 16;
      2: return 64;
      default: return 512;
    endcase
  endfunction

  function automatic int per_pulse(input int sel);
    return (sel == 2) ? 2 : ((sel == 3) ? 0 : 1);
  endfunction

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    wait_cyc(3);
    rstN = 1'b1;
    wait_cyc(1);
    // R1 reset state
    rd_check(2'd0, 0, "R1 mode");
    rd_check(2'd1, 0, "R1 run");
    rd_check(2'd2, 0, "R1 count");
    check("R1 irq", int'(irq), 0);

    // R2 function off: code 00 ignores edges while running
    wr_reg(2'd0, 8'h00); wr_reg(2'd2, 7); wr_reg(2'd1, 1);
    pulse(); pulse();
    rd_check(2'd2, 7, "R2 off mode");
    wr_reg(2'd1, 0);

    // R5 underflow with falling edges, R6 stopped write loads both
    wr_reg(2'd0, 8'h01); wr_reg(2'd2, 3);
    rd_check(2'd2, 3, "R6 stopped load");
    wr_reg(2'd1, 1);
    rd_check(2'd1, 1, "R4 run flag");
    base = irqCount;
    pulse(); rd_check(2'd2, 2, "R3 falling");
    pulse(); pulse(); rd_check(2'd2, 0, "R5 at zero");
    check("R5 no irq yet", irqCount - base, 0);
    pulse(); rd_check(2'd2, 3, "R5 reload");
    check("R5 irq pulse", irqCount - base, 1);

    // R6 write while running loads reload only
    wr_reg(2'd2, 9);
    rd_check(2'd2, 3, "R6 running write");
    for (int i = 0; i < 4; i++) pulse();
    rd_check(2'd2, 9, "R6 reload value");

    // R4 stopped: edges ignored
    wr_reg(2'd1, 0);
    pulse(); pulse();
    rd_check(2'd2, 9, "R4 stopped");

    // R3 random edge selects, R12 timing
    for (int it = 0; it < 8; it++) begin
      int sel, np;
      sel = (it < 4) ? it : int'($urandom_range(0, 3));
      np = int'($urandom_range(1, 12));
      wr_reg(2'd1, 0);
      wr_reg(2'd0, 8'h01 | (sel << 2));
      wr_reg(2'd2, 500);
      wr_reg(2'd1, 1);
      for (int p = 0; p < np; p++) pulse();
      rd_check(2'd2, 500 - np * per_pulse(sel), "R3 edge select");
    end

    // R12 latency: rising edge counted at third edge, not before
    wr_reg(2'd1, 0); wr_reg(2'd0, 8'h05); wr_reg(2'd2, 20); wr_reg(2'd1, 1);
    pinIn = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd_check(2'd2, 20, "R12 not yet");
    @(posedge clk); #1;
    rd_check(2'd2, 19, "R12 third edge");
    wait_cyc(2); pinIn = 1'b0; wait_cyc(4);

    // R7 R9 R10 period measurement
    for (int it = 0; it < 6; it++) begin
      int dc, pol, m, n, idle;
      dc = (it < 4) ? it : int'($urandom_range(0, 3));
      pol = it % 2;
      m = int'($urandom_range(3, 10));
      n = m * div_of(dc) + 1;
      idle = pol ? 0 : 1;
      wr_reg(2'd1, 0);
      pinIn = idle[0]; wait_cyc(5);
      wr_reg(2'd0, 8'h02 | (dc << 6) | (pol << 2));
      wr_reg(2'd1, 1);
      base = irqCount;
      pinIn = ~idle[0]; wait_cyc(1);
      pinIn = idle[0];  wait_cyc(n - 1);
      pinIn = ~idle[0]; wait_cyc(4);
      rd_check(2'd2, m, "R7 R9 period capture");
      check("R10 first capture silent", irqCount - base, 1);
    end

    // R8 width measurement: both edges
    for (int it = 0; it < 3; it++) begin
      int dc, m1, m2, n1, n2;
      dc = int'($urandom_range(0, 2));
      m1 = int'($urandom_range(3, 9));
      m2 = int'($urandom_range(3, 9));
      n1 = m1 * div_of(dc) + 1;
      n2 = m2 * div_of(dc) + 1;
      wr_reg(2'd1, 0);
      pinIn = 1'b0; wait_cyc(5);
      wr_reg(2'd0, 8'h0A | (dc << 6));
      wr_reg(2'd1, 1);
      base = irqCount;
      pinIn = 1'b1; wait_cyc(n1);
      pinIn = 1'b0; wait_cyc(4);
      rd_check(2'd2, m1, "R8 high width");
      check("R10 irq count width", irqCount - base, 1);
      wait_cyc(n2 - 4);
      pinIn = 1'b1; wait_cyc(4);
      rd_check(2'd2, m2, "R8 low width");
      check("R10 irq count width 2", irqCount - base, 2);
    end

    // R11 overflow flag
    wr_reg(2'd1, 0);
    pinIn = 1'b0; wait_cyc(5);
    wr_reg(2'd0, 8'h02);
    rd_check(2'd0, 8'h02, "R11 clear");
    wr_reg(2'd1, 1);
    wait_cyc(2 * (1 << W) + 60);
    rd_check(2'd0, 8'h22, "R11 set");
    wr_reg(2'd0, 8'h22);
    rd_check(2'd0, 8'h02, "R11 write clears, bit read-only");
    wr_reg(2'd1, 0);

    summary();
  end
endmodule